// File: doc/BRIEF.md
# Segmented Thermometer DAC Decoder

This block turns a 14-bit sample code into the switch controls of a segmented current-steering DAC array. The code is split three ways. The upper five bits become a thermometer over 31 large elements of equal weight. The middle four bits become a thermometer over 15 smaller elements, each worth one sixteenth of a large one. The lower five bits pass straight through as binary-weighted controls, which together make up a fraction of one small element.

Every element is driven by a complementary pair of controls. The A control steers the element's current to the A output and the B control steers it to the B output, so no element is ever left floating. All pairs are loaded into one register bank on the same clock edge, so the segments cannot skew against one another. A sleep input parks every element on the B output.

Top module: `seg_dac_decoder`

## Requirements
- R1: The code is split into three fields: code[13:9] selects the coarse segment, code[8:5] selects the fine segment, and code[4:0] is the binary segment.
- R2: A coarse field value k sets coarse_a[0] through coarse_a[k-1] to 1 and every other coarse_a bit to 0.
- R3: A fine field value k sets fine_a[0] through fine_a[k-1] to 1 and every other fine_a bit to 0.
- R4: bin_a[j] equals code[j] for j = 0 to 4 when sleep is low.
- R5: For every element, the B control is the inverse of the A control at all times, including reset and sleep.
- R6: When sleep is low, 512 times the number of set coarse_a bits, plus 32 times the number of set fine_a bits, plus the value of bin_a equals the code.
- R7: All outputs change together one clock edge after the code and sleep are sampled, with no extra delay in any segment.
- R8: While sleep is high at a clock edge, every A control is 0 and every B control is 1 after that edge, whatever the code. The first edge with sleep low loads the decoded code again.
- R9: Asserting rst_n low forces every A control to 0 and every B control to 1 at once, without waiting for a clock. After rst_n rises, the outputs stay in that state for two more clock edges, and the third edge loads the decoded code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside the block |
| sleep | input | 1 | When high, parks all elements on output B |
| code | input | 14 | Sample code |
| coarse_a | output | 31 | Steer-to-A controls of the coarse unary elements |
| coarse_b | output | 31 | Steer-to-B controls of the coarse unary elements |
| fine_a | output | 15 | Steer-to-A controls of the fine unary elements |
| fine_b | output | 15 | Steer-to-B controls of the fine unary elements |
| bin_a | output | 5 | Steer-to-A controls of the binary elements |
| bin_b | output | 5 | Steer-to-B controls of the binary elements |

## Verification
The bench builds the block with its default split of five coarse, four fine and five binary bits. With that split, all 16384 codes can be applied one per cycle. This covers every thermometer length in both unary segments, including the full-scale values 31 and 15, and every carry from the fine field into the coarse field. Sleep is held across changing codes, and reset is asserted between clock edges, so the parked state and the synchronous release window are both checked at the ports.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
  localparam int DEF_COARSE_W = 5;
  localparam int DEF_FINE_W   = 4;
  localparam int DEF_BIN_W    = 5;

  // number of unary elements a w-bit thermometer field drives
  function automatic int unary_len(input int w);
    return (1 << w) - 1;
  endfunction
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_sync_n = stage1_q;
endmodule

// File: rtl/seg_therm_dec.sv
module seg_therm_dec #(
  parameter  int W = 5,
  localparam int N = (1 << W) - 1
) (
  input  logic [W-1:0] val,
  output logic [N-1:0] therm
);
  // element i is on when the field value exceeds i
  for (genvar i = 0; i < N; i++) begin : g_el
    assign therm[i] = (val > W'(i));
  end
endmodule

// File: rtl/seg_steer_bank.sv
module seg_steer_bank #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sleep,
  input  logic [N-1:0] din,
  output logic [N-1:0] q_a,
  output logic [N-1:0] q_b
);
  logic [N-1:0] nxt_a;
  logic [N-1:0] nxt_b;

  always_comb begin
    nxt_a = sleep ? '0 : din;
    nxt_b = ~nxt_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_a <= '0;
      q_b <= '1;
    end else begin
      q_a <= nxt_a;
      q_b <= nxt_b;
    end
  end
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder #(
  parameter  int COARSE_W = seg_dac_pkg::DEF_COARSE_W,
  parameter  int FINE_W   = seg_dac_pkg::DEF_FINE_W,
  parameter  int BIN_W    = seg_dac_pkg::DEF_BIN_W,
  localparam int CODE_W   = COARSE_W + FINE_W + BIN_W,
  localparam int COARSE_N = seg_dac_pkg::unary_len(COARSE_W),
  localparam int FINE_N   = seg_dac_pkg::unary_len(FINE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep,
  input  logic [CODE_W-1:0]   code,
  output logic [COARSE_N-1:0] coarse_a,
  output logic [COARSE_N-1:0] coarse_b,
  output logic [FINE_N-1:0]   fine_a,
  output logic [FINE_N-1:0]   fine_b,
  output logic [BIN_W-1:0]    bin_a,
  output logic [BIN_W-1:0]    bin_b
);
  localparam int FINE_LO   = BIN_W;
  localparam int COARSE_LO = BIN_W + FINE_W;

  logic                rst_sync_n;
  logic [COARSE_N-1:0] coarse_therm;
  logic [FINE_N-1:0]   fine_therm;

  seg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seg_therm_dec #(.W(COARSE_W)) u_coarse_dec (
    .val   (code[COARSE_LO +: COARSE_W]),
    .therm (coarse_therm)
  );

  seg_therm_dec #(.W(FINE_W)) u_fine_dec (
    .val   (code[FINE_LO +: FINE_W]),
    .therm (fine_therm)
  );

  seg_steer_bank #(.N(COARSE_N)) u_coarse_bank (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .sleep (sleep),
    .din   (coarse_therm),
    .q_a   (coarse_a),
    .q_b   (coarse_b)
  );

  seg_steer_bank #(.N(FINE_N)) u_fine_bank (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .sleep (sleep),
    .din   (fine_therm),
    .q_a   (fine_a),
    .q_b   (fine_b)
  );

  seg_steer_bank #(.N(BIN_W)) u_bin_bank (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .sleep (sleep),
    .din   (code[BIN_W-1:0]),
    .q_a   (bin_a),
    .q_b   (bin_b)
  );
endmodule

// File: rtl/seg_dac_decoder_chk.sv
module seg_dac_decoder_chk #(
  parameter  int COARSE_W = 5,
  parameter  int FINE_W   = 4,
  parameter  int BIN_W    = 5,
  localparam int CODE_W   = COARSE_W + FINE_W + BIN_W,
  localparam int COARSE_N = (1 << COARSE_W) - 1,
  localparam int FINE_N   = (1 << FINE_W) - 1
) (
  input logic                clk,
  input logic                rst_ok,
  input logic                sleep,
  input logic [CODE_W-1:0]   code,
  input logic [COARSE_N-1:0] coarse_a,
  input logic [COARSE_N-1:0] coarse_b,
  input logic [FINE_N-1:0]   fine_a,
  input logic [FINE_N-1:0]   fine_b,
  input logic [BIN_W-1:0]    bin_a,
  input logic [BIN_W-1:0]    bin_b
);
  assert_pairs_complementary_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (coarse_a == ~coarse_b) && (fine_a == ~fine_b) && (bin_a == ~bin_b));

  assert_coarse_thermometer_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (coarse_a & (coarse_a + COARSE_N'(1))) == '0);

  assert_fine_thermometer_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (fine_a & (fine_a + FINE_N'(1))) == '0);

  assert_sleep_parks_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    sleep |=> (coarse_a == '0) && (fine_a == '0) && (bin_a == '0));

  assert_bin_passthrough_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    !sleep |=> bin_a == $past(code[BIN_W-1:0]));

  assert_weight_sum_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    !sleep |=> ((32'($countones(coarse_a)) << (FINE_W + BIN_W))
              + (32'($countones(fine_a)) << BIN_W)
              + 32'(bin_a)) == 32'($past(code)));
endmodule

bind seg_dac_decoder seg_dac_decoder_chk #(
  .COARSE_W (COARSE_W),
  .FINE_W   (FINE_W),
  .BIN_W    (BIN_W)
) u_chk (
  .clk      (clk),
  .rst_ok   (rst_sync_n),
  .sleep    (sleep),
  .code     (code),
  .coarse_a (coarse_a),
  .coarse_b (coarse_b),
  .fine_a   (fine_a),
  .fine_b   (fine_b),
  .bin_a    (bin_a),
  .bin_b    (bin_b)
);

// File: tb/seg_dac_decoder_tb.sv
module seg_dac_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic        clk;
  logic        rst_n;
  logic        sleep;
  logic [13:0] code;
  logic [30:0] coarse_a, coarse_b;
  logic [14:0] fine_a, fine_b;
  logic [4:0]  bin_a, bin_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  seg_dac_decoder u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .code     (code),
    .coarse_a (coarse_a),
    .coarse_b (coarse_b),
    .fine_a   (fine_a),
    .fine_b   (fine_b),
    .bin_a    (bin_a),
    .bin_b    (bin_b)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // reference model: the A controls packed as {coarse, fine, bin}
  function automatic logic [50:0] model_a(input int c, input bit slp);
    logic [63:0] crs;
    logic [63:0] fin;
    int k_c;
    int k_f;
    if (slp) return '0;
    k_c = c / 512;
    k_f = (c / 32) % 16;
    crs = (64'd1 << k_c) - 64'd1;
    fin = (64'd1 << k_f) - 64'd1;
    return {crs[30:0], fin[14:0], 5'(c % 32)};
  endfunction

  function automatic logic [50:0] got_a();
    return {coarse_a, fine_a, bin_a};
  endfunction

  function automatic logic [50:0] got_b();
    return {coarse_b, fine_b, bin_b};
  endfunction

  task automatic check(input string req, input logic [50:0] act, input logic [50:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_pair(input string req, input logic [50:0] exp_a);
    check(req, got_a(), exp_a);
    check({req, " R5"}, got_b(), ~exp_a);
  endtask

  // apply code/sleep, cross one edge, compare at the following falling edge
  task automatic step(input int c, input bit slp, input string req);
    int sum;
    code  = 14'(c);
    sleep = slp;
    @(posedge clk);
    @(negedge clk);
    check_pair(req, model_a(c, slp));
    if (!slp) begin
      sum = 512 * $countones(coarse_a) + 32 * $countones(fine_a) + int'(bin_a);
      check("R6 weight sum", 51'(sum), 51'(c));
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    sleep = 1'b0;
    code  = 14'h3FFF;
    repeat (3) @(negedge clk);
    check_pair("R9 reset state", '0);

    // release: two edges still parked, third loads
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check_pair("R9 release edge 1", '0);
    @(posedge clk); @(negedge clk);
    check_pair("R9 release edge 2", '0);
    step(16'h3FFF, 1'b0, "R9 third edge loads");

    // every code once, each on its own edge: R1 R2 R3 R4 R7
    for (int c = 0; c < 16384; c++) step(c, 1'b0, "R1 R2 R3 R4 R7 decode");

    // latency with alternating extremes
    step(0, 1'b0, "R7 one edge");
    step(16383, 1'b0, "R7 one edge");
    step(512, 1'b0, "R2 coarse carry");
    step(511, 1'b0, "R3 fine full");

    // sleep held over changing codes
    step(16'h2A5B, 1'b1, "R8 sleep parks");
    step(16383, 1'b1, "R8 sleep parks");
    step(16'h1234, 1'b1, "R8 sleep held");
    step(16'h1234, 1'b0, "R8 wake loads");
    step(16'h0421, 1'b0, "R8 after wake");

    // asynchronous reset between edges
    step(16383, 1'b0, "R9 before async");
    #(CLK_PERIOD / 4);
    rst_n = 1'b0;
    #1;
    check_pair("R9 async assert", '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check_pair("R9 re-release edge 1", '0);
    @(posedge clk); @(negedge clk);
    check_pair("R9 re-release edge 2", '0);
    step(16'h1F0F, 1'b0, "R9 re-release loads");

    finish_run();
  end
endmodule